// File: doc/BRIEF.md
# Serial Audio Bit Clock and Sample Interrupt Generator

This block generates the bit clock, the word strobe and the serial data line of a stereo serial audio transmitter from the system clock. It also raises an interrupt once per sample period so that software can refill the two 32-bit channel words. An 8-bit divide value sets how many system clocks make one bit period: each bit lasts (divide + 1) system clocks. A stereo frame carries 64 bits, a left word followed by a right word. The sample rate is therefore the system clock divided by 64 and then by (divide + 1).

A small write port gives access to four registers: the divide value, a mode register and the two channel words. The mode register holds the run enable, the word strobe enable and three interrupt sources. Those sources are entry into the right word (strobe rising), entry into the left word (strobe falling) and the start of every word. Two status bits show the current strobe level and which channel is on the line.

Top module: `i2s_sample_clock_gen`

## Requirements
- R1: After reset the divide value is 8, all mode bits are clear, the bit clock, strobe, data and interrupt outputs are low, and the status reads 2'b10.
- R2: Register select 0 writes the divide value, and only the low 8 bits of the write data are kept.
- R3: While running, one bit period lasts (divide + 1) system clocks and a frame lasts 64 bit periods, so equal interrupt events repeat every 64*(divide + 1) system clocks.
- R4: A divide write restarts the frame at bit 0 of the left word in the following cycle. The first right-word entry then follows 32*(divide + 1) cycles after the write edge.
- R5: Register select 1 writes the mode: bit 0 run, bit 2 strobe enable, bit 3 interrupt on strobe rising, bit 4 interrupt on strobe falling, bit 5 interrupt at every word start. With bit 0 clear, the bit clock, strobe, data and interrupt stay low and the frame is held at its start.
- R6: When strobe enable and run are set, the word strobe is low during the left word and high during the right word. When strobe enable is clear, the strobe stays low.
- R7: Status bit 0 equals the word strobe output. Status bit 1 is 1 while the left word is on the line, even with the strobe disabled.
- R8: With mode bit 3 set, an interrupt is raised in the cycle the right word begins.
- R9: With mode bit 4 set, an interrupt is raised in the cycle a frame wraps back into the left word. The start of the first frame after run or restart raises none.
- R10: With mode bit 5 set, an interrupt is raised at the start of each word after the first, every 32*(divide + 1) cycles.
- R11: The interrupt is a one-cycle pulse. Sources that coincide give a single pulse.
- R12: Register select 2 writes the right word and select 3 the left word. Each word is sent MSB first, left word first. The data line changes only while the bit clock is low, which it is for the first floor((divide + 1)/2) cycles of each bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 divide, 1 mode, 2 right word, 3 left word |
| cfg_wdata | input | 32 | Register write data |
| sclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word strobe, high for the right channel |
| sd_o | output | 1 | Serial data, MSB first |
| irq_o | output | 1 | One-cycle sample interrupt pulse |
| status_o | output | 2 | Bit 1 left channel active, bit 0 word strobe level |

## Verification
A miscounted prescaler or bit index shows at once in the spacing of interrupt pulses, which can be measured to the exact system cycle. It also shows in the phase of the strobe against those pulses, so a one-off error appears within one frame. A wrong load or shift in the data path shows at the data line as wrong bits, sampled on bit clock rising edges across one frame. A restart that fails to clear state shows as a wrong delay from the divide write to the first interrupt.

// File: rtl/i2s_gen_pkg.sv
package i2s_gen_pkg;

  // mode register bit positions (decoded by software, so fixed)
  localparam int MODE_RUN_BIT  = 0;
  localparam int MODE_WSEN_BIT = 2;
  localparam int MODE_RISE_BIT = 3;
  localparam int MODE_FALL_BIT = 4;
  localparam int MODE_WORD_BIT = 5;

  typedef enum logic [1:0] {
    SEL_DIV   = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_RIGHT = 2'd2,
    SEL_LEFT  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic run;
    logic ws_en;
    logic irq_rise;
    logic irq_fall;
    logic irq_word;
  } mode_t;

endpackage

// File: rtl/i2s_cfg_regs.sv
module i2s_cfg_regs
  import i2s_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int WORD_W  = 32,
  parameter int DIV_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_q,
  output mode_t             mode_q,
  output logic [WORD_W-1:0] right_q,
  output logic [WORD_W-1:0] left_q,
  output logic              div_wr
);

  logic [WORD_W-1:0] word_q [2];

  assign div_wr = we && (sel == SEL_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= DIV_W'(DIV_RST);
      mode_q <= '0;
    end else if (we) begin
      if (sel == SEL_DIV) div_q <= wdata[DIV_W-1:0];
      if (sel == SEL_MODE) begin
        mode_q.run      <= wdata[MODE_RUN_BIT];
        mode_q.ws_en    <= wdata[MODE_WSEN_BIT];
        mode_q.irq_rise <= wdata[MODE_RISE_BIT];
        mode_q.irq_fall <= wdata[MODE_FALL_BIT];
        mode_q.irq_word <= wdata[MODE_WORD_BIT];
      end
    end
  end

  // channel 0 = right (select 2), channel 1 = left (select 3)
  for (genvar ch = 0; ch < 2; ch++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[ch] <= '0;
      else if (we && (sel == 2'(SEL_RIGHT + ch)))
        word_q[ch] <= wdata;
    end
  end

  assign right_q = word_q[0];
  assign left_q  = word_q[1];

  a_r2_div_low_byte: assert property (@(posedge clk) disable iff (rst)
    div_wr |=> (div_q == $past(wdata[DIV_W-1:0])));

endmodule

// File: rtl/i2s_frame_timer.sv
module i2s_frame_timer #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 32,
  localparam int FRAME_BITS = 2 * WORD_W,
  localparam int IDX_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             word_en,
  output logic [DIV_W-1:0] pre_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             tick,
  output logic             irq_q
);

  logic enter_right, enter_left;

  assign tick        = run && !restart && (pre_q == div);
  assign idx_nxt     = (idx_q == IDX_W'(FRAME_BITS - 1)) ? '0 : idx_q + 1'b1;
  assign enter_right = (idx_nxt == IDX_W'(WORD_W));
  assign enter_left  = (idx_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre_q <= '0;
      idx_q <= '0;
      irq_q <= 1'b0;
    end else if (tick) begin
      pre_q <= '0;
      idx_q <= idx_nxt;
      irq_q <= (rise_en && enter_right) || (fall_en && enter_left) ||
               (word_en && (enter_right || enter_left));
    end else begin
      pre_q <= pre_q + 1'b1;
      irq_q <= 1'b0;
    end
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  a_r5_idle_no_irq: assert property (@(posedge clk) disable iff (rst)
    !run |=> !irq_q);

  a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (idx_q == '0) && (pre_q == '0));

endmodule

// File: rtl/i2s_word_shifter.sv
module i2s_word_shifter #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(2 * WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              tick,
  input  logic [IDX_W-1:0]  idx_nxt,
  input  logic [WORD_W-1:0] left_word,
  input  logic [WORD_W-1:0] right_word,
  output logic              msb
);

  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)
      sh_q <= '0;
    else if (hold)
      sh_q <= left_word;
    else if (tick) begin
      if (idx_nxt == '0)
        sh_q <= left_word;
      else if (idx_nxt == IDX_W'(WORD_W))
        sh_q <= right_word;
      else
        sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  assign msb = sh_q[WORD_W-1];

  a_r12_hold_loads_left: assert property (@(posedge clk) disable iff (rst)
    hold |=> (sh_q == $past(left_word)));

endmodule

// File: rtl/i2s_sample_clock_gen.sv
module i2s_sample_clock_gen
  import i2s_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int WORD_W  = 32,
  parameter int DIV_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              sclk_o,
  output logic              ws_o,
  output logic              sd_o,
  output logic              irq_o,
  output logic [1:0]        status_o
);

  localparam int IDX_W = $clog2(2 * WORD_W);

  logic [DIV_W-1:0]  div_q, pre_q;
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [WORD_W-1:0] right_q, left_q;
  logic [DIV_W:0]    half;
  mode_t             mode_q;
  logic              div_wr, tick, msb, hold, in_left;

  i2s_cfg_regs #(.DIV_W(DIV_W), .WORD_W(WORD_W), .DIV_RST(DIV_RST)) i_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .div_q(div_q), .mode_q(mode_q), .right_q(right_q), .left_q(left_q),
    .div_wr(div_wr)
  );

  i2s_frame_timer #(.DIV_W(DIV_W), .WORD_W(WORD_W)) i_timer (
    .clk(clk), .rst(rst), .run(mode_q.run), .restart(div_wr), .div(div_q),
    .rise_en(mode_q.irq_rise), .fall_en(mode_q.irq_fall),
    .word_en(mode_q.irq_word), .pre_q(pre_q), .idx_q(idx_q),
    .idx_nxt(idx_nxt), .tick(tick), .irq_q(irq_o)
  );

  assign hold = !mode_q.run || div_wr;

  i2s_word_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst(rst), .hold(hold), .tick(tick), .idx_nxt(idx_nxt),
    .left_word(left_q), .right_word(right_q), .msb(msb)
  );

  assign half     = ({1'b0, div_q} + 1'b1) >> 1;
  assign in_left  = (idx_q < IDX_W'(WORD_W));
  assign sclk_o   = mode_q.run && ({1'b0, pre_q} >= half);
  assign ws_o     = mode_q.run && mode_q.ws_en && !in_left;
  assign sd_o     = mode_q.run && msb;
  assign status_o = {in_left, ws_o};

endmodule

// File: tb/test_i2s_sample_clock_gen.sv
module test_i2s_sample_clock_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        sclk_o, ws_o, sd_o, irq_o;
  logic [1:0]  status_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  i2s_sample_clock_gen i_i2s_sample_clock_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o),
    .irq_o(irq_o), .status_o(status_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // idle first so the frame restarts, then apply the new mode
  task automatic start_mode(input logic [31:0] m);
    wr(2'd1, 32'h0);
    wr(2'd1, m);
  endtask

  // count negedges until irq is seen high
  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic next_interval(output int n);
    @(negedge clk);
    check(irq_o == 1'b0, "R11 pulse width", irq_o, 0);
    n = 1;
    while (!irq_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    check(sclk_o == 0 && ws_o == 0 && sd_o == 0 && irq_o == 0, "R1 idle outputs",
          {sclk_o, ws_o, sd_o, irq_o}, 0);
    check(status_o == 2'b10, "R1 status", status_o, 2'b10);
  endtask

  task automatic t_default_rate;
    int n;
    start_mode(32'h0D);
    wait_irq(n);
    check(n == 32 * 9, "R4 first rise at default divide 8", n, 32 * 9);
    check(ws_o == 1'b1, "R8 strobe high at rise irq", ws_o, 1);
    check(status_o == 2'b01, "R7 status right channel", status_o, 2'b01);
    next_interval(n);
    check(n == 64 * 9, "R3 frame period divide 8", n, 64 * 9);
  endtask

  task automatic t_divide_write;
    int n;
    wr(2'd0, 32'h1);
    wait_irq(n);
    check(n == 64, "R4 restart after divide write", n, 64);
    next_interval(n);
    check(n == 128, "R3 frame period divide 1", n, 128);
  endtask

  task automatic t_low_bits;
    int n;
    wr(2'd0, 32'hFFFF_FF03);
    wait_irq(n);
    check(n == 32 * 4, "R2 only low byte of divide used", n, 128);
    wr(2'd0, 32'h1);
  endtask

  task automatic t_fall;
    int n;
    start_mode(32'h15);
    wait_irq(n);
    check(n == 128, "R9 first fall irq at frame wrap", n, 128);
    check(ws_o == 1'b0, "R6 strobe low in left word", ws_o, 0);
    check(status_o == 2'b10, "R7 status left channel", status_o, 2'b10);
  endtask

  task automatic t_word;
    int n;
    start_mode(32'h21);
    wait_irq(n);
    check(n == 64, "R10 first word irq", n, 64);
    next_interval(n);
    check(n == 64, "R10 word irq interval", n, 64);
  endtask

  task automatic t_all;
    int n;
    start_mode(32'h39);
    wait_irq(n);
    check(n == 64, "R11 combined first", n, 64);
    next_interval(n);
    check(n == 64, "R11 coinciding sources one pulse", n, 64);
    next_interval(n);
    check(n == 64, "R11 coinciding sources one pulse again", n, 64);
  endtask

  task automatic t_wsen_off;
    int n;
    start_mode(32'h09);
    wait_irq(n);
    check(n == 64, "R8 rise irq without strobe", n, 64);
    check(ws_o == 1'b0, "R6 strobe disabled stays low", ws_o, 0);
    check(status_o == 2'b00, "R7 channel bit without strobe", status_o, 2'b00);
  endtask

  task automatic t_idle;
    int bad = 0;
    start_mode(32'h3C);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq_o || sclk_o || ws_o || sd_o) bad++;
    end
    check(bad == 0, "R5 run clear keeps outputs low", bad, 0);
    check(status_o == 2'b10, "R5 frame held at start", status_o, 2'b10);
  endtask

  task automatic t_data;
    logic [31:0] lw, rw, got_l, got_r;
    int wsbad = 0;
    int caught = 0;
    int guard = 0;
    logic prev;
    lw = 32'hA5C3_0F81;
    rw = 32'h1234_5678;
    wr(2'd3, lw);
    wr(2'd2, rw);
    start_mode(32'h05);
    prev = sclk_o;
    while (caught < 64 && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (sclk_o && !prev) begin
        if (caught < 32) begin
          got_l[31 - caught] = sd_o;
          if (ws_o) wsbad++;
        end else begin
          got_r[63 - caught] = sd_o;
          if (!ws_o) wsbad++;
        end
        caught++;
      end
      prev = sclk_o;
    end
    check(caught == 64, "R12 bit clock rising edges per frame", caught, 64);
    check(got_l == lw, "R12 left word MSB first", got_l, lw);
    check(got_r == rw, "R12 right word MSB first", got_r, rw);
    check(wsbad == 0, "R6 strobe per channel", wsbad, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_default_rate();
    t_divide_write();
    t_low_bits();
    t_fall();
    t_word();
    t_all();
    t_wsen_off();
    t_idle();
    t_data();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule